// File: doc/BRIEF.md
# PCI Window Address Translator

This block turns 32-bit PCI bus addresses into 34-bit DMA memory addresses. It uses a set of programmable windows, four by default. Each window holds three 64-bit registers: a base, a mask and a translated base. A 64-bit register port reads and writes them. When a window claims an address, it either maps the address directly or runs a scatter-gather lookup. A direct mapping keeps the offset bits of the bus address and takes every other bit from the translated base. A scatter-gather lookup reads a 64-bit page-table entry through a memory read port and builds the DMA address from that entry.

Translation uses a valid/ready request and a valid/ready response. Only one translation is in flight at a time. The controller is a four-state machine:
- `XS_IDLE` accepts a request and decodes it in the same cycle. A miss or a direct hit goes to `XS_RESP`. A scatter-gather hit goes to `XS_FETCH`.
- `XS_FETCH` holds the memory read request until the memory accepts it, then goes to `XS_WAIT`.
- `XS_WAIT` waits for the returned entry, then goes to `XS_RESP`.
- `XS_RESP` holds the result until the requester takes it, then returns to `XS_IDLE`.

When a translation is accepted, the block latches everything it needs from the registers. A register write made while that translation is in flight therefore only affects later requests.

Top module: `pci_window_xlate`

## Requirements
- R1: After reset, every window register reads zero, `xl_req_ready` is high, and `xl_rsp_valid` and `mem_req_valid` are low.
- R2: Register accesses use byte offset `reg_addr` and size `reg_size` in bytes. The register index is `reg_addr >> 6`. Window registers are at these indexes:
  - base of window w: index w
  - mask of window w: index 4+w
  - translated base of window w: index 8+w

  An access with size 8 to one of these indexes reads back the last value written. Its response (`reg_rsp_valid`, `reg_rdata`, `reg_err`) appears one cycle after `reg_valid`.
- R3: Indexes 12 (control), 13 (error) and 14 (TLB invalidate-all) read zero, ignore writes and report no error.
- R4: Any size other than 8, or any index above 14, sets `reg_err`, returns zero read data and changes no register.
- R5: A window is compared on bus address bits 30:20 only. It matches when those bits equal its base bits at every position where its mask bit is zero. Base bit 0 enables the window. Base bit 1 selects scatter-gather mode.
- R6: Windows are searched from index 0 upward, and the first window that is both enabled and matching is used. A window that matches but is disabled does not end the search.
- R7: In direct mode, the offset field is mask bits 30:20 plus bits 19:0. The result takes the offset-field bits from the bus address and all other bits from the translated base.
- R8: In scatter-gather mode, the entry address is built in three steps:
  - Take the translated base and clear the bits set in ((mask & bits 30:20) >> 10) | 0x3FF.
  - Take the bus address, keep only mask bits 30:20 plus bits 19:13, and shift it right by 10.
  - Combine the two parts with OR.

  The entry address is issued on `mem_req_addr` and held while `mem_req_valid` is high and `mem_req_ready` is low.
- R9: The scatter-gather result is the returned entry with bit 0 cleared, shifted left 12, combined with OR with bus address bits 12:0.
- R10: Every result is cut to 34 bits. When no window is enabled and matching, the response carries address zero and `xl_rsp_miss` high; otherwise `xl_rsp_miss` is low.
- R11: `xl_req_ready` is high only when no translation is in flight. A response stays valid and unchanged until `xl_rsp_ready` is high.
- R12: A register write made while a translation is in flight does not change that translation. It applies to the next request.
- R13: Results are due at fixed points relative to the edge that accepts a request:
  - For a miss or direct hit, `xl_rsp_valid` is high in the cycle after that edge.
  - For a scatter-gather hit, `mem_req_valid` is high in the cycle after that edge.
  - For a scatter-gather hit, `xl_rsp_valid` rises in the cycle after the edge that sees `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Byte offset from block base |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data |
| reg_rsp_valid | output | 1 | Register response valid |
| reg_rdata | output | 64 | Read data |
| reg_err | output | 1 | Bad size or index |
| xl_req_valid | input | 1 | Translation request valid |
| xl_req_ready | output | 1 | Translator idle and able to accept |
| xl_req_addr | input | 32 | PCI bus address |
| xl_rsp_valid | output | 1 | Translation result valid |
| xl_rsp_ready | input | 1 | Requester takes the result |
| xl_rsp_addr | output | DMA_AW | DMA address |
| xl_rsp_miss | output | 1 | No window claimed the address |
| mem_req_valid | output | 1 | Page-table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | DMA_AW | Entry address |
| mem_rsp_valid | input | 1 | Entry returned |
| mem_rsp_data | input | 64 | Entry value |

## Verification
Each check is sampled at the falling edge after the rising edge that should produce the result:
- Register data is sampled one cycle after the access.
- A miss or direct result is sampled one cycle after the request is accepted.
- For a scatter-gather hit, the entry read request is sampled one cycle after acceptance, and the final result one cycle after the entry returns.

The bench holds `mem_req_ready` low for at least one cycle and sometimes holds `xl_rsp_ready` low. It then re-samples on the following cycles to confirm that the request and the response stay unchanged. Two window layouts are swept over all 2048 values of bus bits 30:20. Expected values come from a bit-by-bit model in the bench.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

    localparam int QW              = 64;
    localparam int BUS_W           = 32;
    localparam int REG_IDX_SHIFT   = 6;
    localparam logic [3:0] ACCESS_BYTES = 4'd8;

    // Bit fields used by the window decode
    localparam logic [QW-1:0] WIN_CMP_FIELD  = 64'h0000_0000_7FF0_0000; // bits 30:20
    localparam logic [QW-1:0] PAGE_OFF_FIELD = 64'h0000_0000_000F_FFFF; // bits 19:0
    localparam logic [QW-1:0] SG_IDX_FIELD   = 64'h0000_0000_000F_E000; // bits 19:13
    localparam logic [QW-1:0] ENTRY_LOW_CLR  = 64'h0000_0000_0000_03FF;
    localparam int ENTRY_SHIFT = 10;
    localparam int PAGE_SHIFT  = 12;
    localparam int PAGE_BITS   = 13;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_FETCH = 2'd1,
        XS_WAIT  = 2'd2,
        XS_RESP  = 2'd3
    } xl_state_e;

    typedef enum logic [2:0] {
        RK_BASE  = 3'd0,
        RK_MASK  = 3'd1,
        RK_TBASE = 3'd2,
        RK_ZERO  = 3'd3,
        RK_BAD   = 3'd4
    } reg_kind_e;

endpackage

// File: rtl/pwx_regfile.sv
module pwx_regfile
    import pwx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int REG_AW  = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_valid,
    input  logic                         reg_write,
    input  logic [REG_AW-1:0]            reg_addr,
    input  logic [3:0]                   reg_size,
    input  logic [QW-1:0]                reg_wdata,
    output logic                         reg_rsp_valid,
    output logic [QW-1:0]                reg_rdata,
    output logic                         reg_err,
    output logic [NUM_WIN-1:0][QW-1:0]   win_base,
    output logic [NUM_WIN-1:0][QW-1:0]   win_mask,
    output logic [NUM_WIN-1:0][QW-1:0]   win_tbase
);

    localparam int IDX_W  = REG_AW - REG_IDX_SHIFT;
    localparam int SLOT_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam logic [IDX_W-1:0] MASK_FIRST  = IDX_W'(NUM_WIN);
    localparam logic [IDX_W-1:0] TBASE_FIRST = IDX_W'(2 * NUM_WIN);
    localparam logic [IDX_W-1:0] ZERO_FIRST  = IDX_W'(3 * NUM_WIN);
    localparam logic [IDX_W-1:0] ZERO_END    = IDX_W'(3 * NUM_WIN + 3);

    logic [IDX_W-1:0]  idx;
    reg_kind_e         kind;
    logic [SLOT_W-1:0] slot;
    logic [QW-1:0]     rd_mux;
    logic              wr_en;

    logic [NUM_WIN-1:0][QW-1:0] base_q, mask_q, tbase_q;

    logic          rsp_valid_q, err_q;
    logic [QW-1:0] rdata_q;

    assign idx   = reg_addr[REG_AW-1:REG_IDX_SHIFT];
    assign wr_en = reg_valid && reg_write;

    always_comb begin
        kind = RK_BAD;
        slot = '0;
        if (reg_size != ACCESS_BYTES) begin
            kind = RK_BAD;
        end else if (idx < MASK_FIRST) begin
            kind = RK_BASE;
            slot = SLOT_W'(idx);
        end else if (idx < TBASE_FIRST) begin
            kind = RK_MASK;
            slot = SLOT_W'(idx - MASK_FIRST);
        end else if (idx < ZERO_FIRST) begin
            kind = RK_TBASE;
            slot = SLOT_W'(idx - TBASE_FIRST);
        end else if (idx < ZERO_END) begin
            kind = RK_ZERO;
        end
    end

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    base_q[w]  <= '0;
                    mask_q[w]  <= '0;
                    tbase_q[w] <= '0;
                end else if (wr_en && slot == SLOT_W'(w)) begin
                    if (kind == RK_BASE)  base_q[w]  <= reg_wdata;
                    if (kind == RK_MASK)  mask_q[w]  <= reg_wdata;
                    if (kind == RK_TBASE) tbase_q[w] <= reg_wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        unique case (kind)
            RK_BASE:  rd_mux = base_q[slot];
            RK_MASK:  rd_mux = mask_q[slot];
            RK_TBASE: rd_mux = tbase_q[slot];
            RK_ZERO:  rd_mux = '0;
            RK_BAD:   rd_mux = '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            err_q       <= 1'b0;
            rdata_q     <= '0;
        end else begin
            rsp_valid_q <= reg_valid;
            err_q       <= reg_valid && (kind == RK_BAD);
            rdata_q     <= (reg_valid && !reg_write) ? rd_mux : '0;
        end
    end

    assign reg_rsp_valid = rsp_valid_q;
    assign reg_rdata     = rdata_q;
    assign reg_err       = err_q;
    assign win_base      = base_q;
    assign win_mask      = mask_q;
    assign win_tbase     = tbase_q;

endmodule

// File: rtl/pwx_window_select.sv
module pwx_window_select
    import pwx_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic [BUS_W-1:0]             bus_addr,
    input  logic [NUM_WIN-1:0][QW-1:0]   win_base,
    input  logic [NUM_WIN-1:0][QW-1:0]   win_mask,
    input  logic [NUM_WIN-1:0][QW-1:0]   win_tbase,
    output logic                         sel_hit,
    output logic                         sel_sg,
    output logic [QW-1:0]                sel_direct,
    output logic [QW-1:0]                sel_entry
);

    logic [QW-1:0] bus_q;
    logic [NUM_WIN-1:0]         hit;
    logic [NUM_WIN-1:0][QW-1:0] direct;
    logic [NUM_WIN-1:0][QW-1:0] entry;

    assign bus_q = {{(QW-BUS_W){1'b0}}, bus_addr};

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
            logic [QW-1:0] mfield, cmp_bits, off_bits, keep_bits, idx_bits;
            always_comb begin
                mfield    = win_mask[w] & WIN_CMP_FIELD;
                cmp_bits  = ~win_mask[w] & WIN_CMP_FIELD;
                hit[w]    = win_base[w][0] &&
                            (((bus_q ^ win_base[w]) & cmp_bits) == '0);
                off_bits  = mfield | PAGE_OFF_FIELD;
                direct[w] = (win_tbase[w] & ~off_bits) | (bus_q & off_bits);
                keep_bits = ~((mfield >> ENTRY_SHIFT) | ENTRY_LOW_CLR);
                idx_bits  = mfield | SG_IDX_FIELD;
                entry[w]  = (win_tbase[w] & keep_bits) |
                            ((bus_q & idx_bits) >> ENTRY_SHIFT);
            end
        end
    endgenerate

    // lowest-numbered enabled, matching window wins
    always_comb begin
        sel_hit    = 1'b0;
        sel_sg     = 1'b0;
        sel_direct = '0;
        sel_entry  = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (hit[w] && !sel_hit) begin
                sel_hit    = 1'b1;
                sel_sg     = win_base[w][1];
                sel_direct = direct[w];
                sel_entry  = entry[w];
            end
        end
    end

endmodule

// File: rtl/pci_window_xlate.sv
module pci_window_xlate
    import pwx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int REG_AW  = 12,
    parameter int DMA_AW  = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [3:0]        reg_size,
    input  logic [63:0]       reg_wdata,
    output logic              reg_rsp_valid,
    output logic [63:0]       reg_rdata,
    output logic              reg_err,
    input  logic              xl_req_valid,
    output logic              xl_req_ready,
    input  logic [31:0]       xl_req_addr,
    output logic              xl_rsp_valid,
    input  logic              xl_rsp_ready,
    output logic [DMA_AW-1:0] xl_rsp_addr,
    output logic              xl_rsp_miss,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [DMA_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);

    logic [NUM_WIN-1:0][QW-1:0] win_base, win_mask, win_tbase;
    logic          sel_hit, sel_sg;
    logic [QW-1:0] sel_direct, sel_entry;

    xl_state_e state_q, state_d;

    logic [PAGE_BITS-1:0] page_off_q;
    logic [DMA_AW-1:0]    entry_q, result_q;
    logic                 miss_q;
    logic [QW-1:0]        sg_full;
    logic                 accept;

    pwx_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_valid     (reg_valid),
        .reg_write     (reg_write),
        .reg_addr      (reg_addr),
        .reg_size      (reg_size),
        .reg_wdata     (reg_wdata),
        .reg_rsp_valid (reg_rsp_valid),
        .reg_rdata     (reg_rdata),
        .reg_err       (reg_err),
        .win_base      (win_base),
        .win_mask      (win_mask),
        .win_tbase     (win_tbase)
    );

    pwx_window_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .bus_addr   (xl_req_addr),
        .win_base   (win_base),
        .win_mask   (win_mask),
        .win_tbase  (win_tbase),
        .sel_hit    (sel_hit),
        .sel_sg     (sel_sg),
        .sel_direct (sel_direct),
        .sel_entry  (sel_entry)
    );

    assign accept = (state_q == XS_IDLE) && xl_req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:  if (xl_req_valid) state_d = (sel_hit && sel_sg) ? XS_FETCH : XS_RESP;
            XS_FETCH: if (mem_req_ready) state_d = XS_WAIT;
            XS_WAIT:  if (mem_rsp_valid) state_d = XS_RESP;
            XS_RESP:  if (xl_rsp_ready)  state_d = XS_IDLE;
            default:  state_d = XS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        xl_req_ready  = 1'b0;
        mem_req_valid = 1'b0;
        xl_rsp_valid  = 1'b0;
        unique case (state_q)
            XS_IDLE:  xl_req_ready  = 1'b1;
            XS_FETCH: mem_req_valid = 1'b1;
            XS_WAIT:  ;
            XS_RESP:  xl_rsp_valid  = 1'b1;
            default:  ;
        endcase
    end

    assign sg_full = ({mem_rsp_data[QW-1:1], 1'b0} << PAGE_SHIFT) |
                     {{(QW-PAGE_BITS){1'b0}}, page_off_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_off_q <= '0;
            entry_q    <= '0;
            result_q   <= '0;
            miss_q     <= 1'b0;
        end else begin
            if (accept) begin
                page_off_q <= xl_req_addr[PAGE_BITS-1:0];
                entry_q    <= sel_entry[DMA_AW-1:0];
                miss_q     <= !sel_hit;
                result_q   <= sel_hit ? sel_direct[DMA_AW-1:0] : '0;
            end else if (state_q == XS_WAIT && mem_rsp_valid) begin
                result_q   <= sg_full[DMA_AW-1:0];
                miss_q     <= 1'b0;
            end
        end
    end

    assign xl_rsp_addr  = result_q;
    assign xl_rsp_miss  = miss_q;
    assign mem_req_addr = entry_q;

endmodule

// File: rtl/pwx_checker.sv
module pwx_checker #(
    parameter int DMA_AW = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_rsp_valid,
    input logic [63:0]       reg_rdata,
    input logic              reg_err,
    input logic              xl_req_ready,
    input logic              xl_rsp_valid,
    input logic              xl_rsp_ready,
    input logic [DMA_AW-1:0] xl_rsp_addr,
    input logic              xl_rsp_miss,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [DMA_AW-1:0] mem_req_addr
);

    AST_REG_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid |=> reg_rsp_valid); // R2

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rsp_valid && reg_err) |-> (reg_rdata == '0)); // R4

    AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_rsp_valid && xl_rsp_miss) |-> (xl_rsp_addr == '0)); // R10

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_rsp_valid && !xl_rsp_ready) |=>
        (xl_rsp_valid && $stable(xl_rsp_addr) && $stable(xl_rsp_miss))); // R11

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_rsp_valid || mem_req_valid) |-> !xl_req_ready); // R11

    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr))); // R8

    AST_MEM_NOT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !xl_rsp_valid); // R13

endmodule

bind pci_window_xlate pwx_checker #(.DMA_AW(DMA_AW)) u_pwx_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_valid     (reg_valid),
    .reg_rsp_valid (reg_rsp_valid),
    .reg_rdata     (reg_rdata),
    .reg_err       (reg_err),
    .xl_req_ready  (xl_req_ready),
    .xl_rsp_valid  (xl_rsp_valid),
    .xl_rsp_ready  (xl_rsp_ready),
    .xl_rsp_addr   (xl_rsp_addr),
    .xl_rsp_miss   (xl_rsp_miss),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/tb_pci_window_xlate.sv
`timescale 1ns/1ps
module tb_pci_window_xlate;

    localparam logic [63:0] M34 = 64'h3_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [3:0]  reg_size = 4'd8;
    logic [63:0] reg_wdata = '0;
    logic        reg_rsp_valid, reg_err;
    logic [63:0] reg_rdata;
    logic        xl_req_valid = 1'b0, xl_req_ready;
    logic [31:0] xl_req_addr = '0;
    logic        xl_rsp_valid, xl_rsp_ready = 1'b1, xl_rsp_miss;
    logic [33:0] xl_rsp_addr;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] m_base [4];
    logic [63:0] m_mask [4];
    logic [63:0] m_tba  [4];

    always #4 clk = ~clk;

    pci_window_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rsp_valid(reg_rsp_valid),
        .reg_rdata(reg_rdata), .reg_err(reg_err),
        .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready), .xl_req_addr(xl_req_addr),
        .xl_rsp_valid(xl_rsp_valid), .xl_rsp_ready(xl_rsp_ready), .xl_rsp_addr(xl_rsp_addr),
        .xl_rsp_miss(xl_rsp_miss),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_acc(input bit wr, input logic [11:0] off, input logic [3:0] sz,
                           input logic [63:0] wd, output logic [63:0] rd, output bit err);
        int idx;
        @(negedge clk);
        reg_valid = 1'b1; reg_write = wr; reg_addr = off; reg_size = sz; reg_wdata = wd;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        chk(reg_rsp_valid == 1'b1, "R2 rsp_valid", 64'(reg_rsp_valid), 64'd1);
        rd = reg_rdata; err = reg_err;
        idx = int'(off >> 6);
        if (wr && sz == 4'd8 && idx < 12) begin
            if (idx < 4)      m_base[idx]   = wd;
            else if (idx < 8) m_mask[idx-4] = wd;
            else              m_tba[idx-8]  = wd;
        end
    endtask

    task automatic reg_wr(input int idx, input logic [63:0] v);
        logic [63:0] rd; bit e;
        reg_acc(1'b1, 12'(idx << 6), 4'd8, v, rd, e);
        chk(e == 1'b0, "R2 write err", 64'(e), 64'd0);
    endtask

    task automatic reg_rd_chk(input logic [11:0] off, input logic [3:0] sz,
                              input logic [63:0] exp, input bit exp_err, input string req);
        logic [63:0] rd; bit e;
        reg_acc(1'b0, off, sz, 64'd0, rd, e);
        chk(rd == exp, req, rd, exp);
        chk(e == exp_err, req, 64'(e), 64'(exp_err));
    endtask

    // bit-level reference of the window decode
    task automatic model(input logic [31:0] a, output bit hit, output bit sg,
                         output logic [63:0] dir, output logic [63:0] ent);
        hit = 0; sg = 0; dir = '0; ent = '0;
        for (int w = 0; w < 4; w++) begin
            bit m;
            m = m_base[w][0];
            for (int b = 20; b <= 30; b++)
                if (!m_mask[w][b] && (a[b] != m_base[w][b])) m = 0;
            if (m && !hit) begin
                hit = 1; sg = m_base[w][1];
                for (int b = 0; b < 34; b++) begin
                    if (b < 20 || (b <= 30 && m_mask[w][b])) dir[b] = a[b];
                    else dir[b] = m_tba[w][b];
                end
                for (int b = 0; b < 34; b++) begin
                    int src;
                    bit from_bus, clr;
                    src = b + 10;
                    from_bus = (src >= 13 && src <= 19) || (src >= 20 && src <= 30 && m_mask[w][src]);
                    clr = (b < 10) || (b <= 20 && m_mask[w][b+10]);
                    ent[b] = (clr ? 1'b0 : m_tba[w][b]) | (from_bus ? a[src] : 1'b0);
                end
            end
        end
    endtask

    task automatic xlate(input logic [31:0] a, input bit hold_rsp, input bit mid_write);
        bit hit, sg;
        logic [63:0] dir, ent, data, exp;
        model(a, hit, sg, dir, ent);
        xl_rsp_ready = !hold_rsp;
        @(negedge clk);
        chk(xl_req_ready == 1'b1, "R11 ready when idle", 64'(xl_req_ready), 64'd1);
        xl_req_valid = 1'b1; xl_req_addr = a;
        @(negedge clk);
        xl_req_valid = 1'b0;
        chk(xl_req_ready == 1'b0, "R11 busy", 64'(xl_req_ready), 64'd0);
        if (hit && sg) begin
            chk(mem_req_valid == 1'b1 && xl_rsp_valid == 1'b0, "R13 sg fetch timing",
                64'(mem_req_valid), 64'd1);
            chk(64'(mem_req_addr) == ent, "R8 entry address", 64'(mem_req_addr), ent);
            if (mid_write) begin
                reg_wr(8, 64'h0000_0003_5555_0000);
                reg_wr(4, 64'h7FF0_0000);
                chk(64'(mem_req_addr) == ent, "R12 entry unchanged", 64'(mem_req_addr), ent);
            end else begin
                @(negedge clk);
                chk(mem_req_valid == 1'b1 && 64'(mem_req_addr) == ent, "R8 held",
                    64'(mem_req_addr), ent);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk(mem_req_valid == 1'b0, "R8 request dropped", 64'(mem_req_valid), 64'd0);
            data = (ent * 64'h0000_0001_0000_0193) ^ 64'h8000_0000_0000_0001;
            mem_rsp_valid = 1'b1; mem_rsp_data = data;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            exp = (((data & ~64'h1) << 12) | 64'(a[12:0])) & M34;
            chk(xl_rsp_valid == 1'b1, "R13 sg response timing", 64'(xl_rsp_valid), 64'd1);
            chk(64'(xl_rsp_addr) == exp && !xl_rsp_miss, "R9 sg result", 64'(xl_rsp_addr), exp);
        end else begin
            exp = hit ? (dir & M34) : 64'd0;
            chk(xl_rsp_valid == 1'b1, "R13 direct/miss timing", 64'(xl_rsp_valid), 64'd1);
            chk(64'(xl_rsp_addr) == exp, hit ? "R7 direct result" : "R10 miss address",
                64'(xl_rsp_addr), exp);
            chk(xl_rsp_miss == !hit, "R10 miss flag", 64'(xl_rsp_miss), 64'(!hit));
        end
        if (hold_rsp) begin
            @(negedge clk);
            chk(xl_rsp_valid == 1'b1 && 64'(xl_rsp_addr) == exp, "R11 response held",
                64'(xl_rsp_addr), exp);
            xl_rsp_ready = 1'b1;
        end
        @(negedge clk);
        chk(xl_rsp_valid == 1'b0 && xl_req_ready == 1'b1, "R11 response consumed",
            64'(xl_rsp_valid), 64'd0);
    endtask

    task automatic sweep();
        for (int i = 0; i < 2048; i++) begin
            logic [31:0] a;
            a = (32'(i) << 20) | ((32'(i) * 32'h0001_3579) & 32'h000F_FFFF) |
                ((i % 3 == 1) ? 32'h8000_0000 : 32'h0);
            xlate(a, (i % 97) == 5, 1'b0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int w = 0; w < 4; w++) begin m_base[w] = '0; m_mask[w] = '0; m_tba[w] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(xl_req_ready == 1'b1, "R1 ready", 64'(xl_req_ready), 64'd1);
        chk(xl_rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 idle outputs",
            64'(xl_rsp_valid), 64'd0);
        for (int k = 0; k < 12; k++) reg_rd_chk(12'(k << 6), 4'd8, 64'd0, 1'b0, "R1 reg zero");

        // R2 write/readback, low offset bits ignored
        for (int k = 0; k < 12; k++) reg_wr(k, 64'hA5A5_0000_0000_0000 | 64'(k * 64'h1111));
        for (int k = 0; k < 12; k++)
            reg_rd_chk(12'((k << 6) | 6'h18), 4'd8, 64'hA5A5_0000_0000_0000 | 64'(k * 64'h1111),
                       1'b0, "R2 readback");
        // R3 zero registers
        for (int k = 12; k < 15; k++) begin
            reg_wr(k, 64'hFFFF_FFFF_FFFF_FFFF);
            reg_rd_chk(12'(k << 6), 4'd8, 64'd0, 1'b0, "R3 zero register");
        end
        // R4 bad index / size
        begin
            logic [63:0] rd; bit e;
            reg_acc(1'b1, 12'(20 << 6), 4'd8, 64'h1234, rd, e);
            chk(e == 1'b1, "R4 bad index err", 64'(e), 64'd1);
            reg_acc(1'b1, 12'(2 << 6), 4'd4, 64'hDEAD, rd, e);
            chk(e == 1'b1, "R4 bad size err", 64'(e), 64'd1);
            reg_rd_chk(12'(2 << 6), 4'd8, 64'hA5A5_0000_0000_2222, 1'b0, "R4 no change");
            reg_rd_chk(12'(63 << 6), 4'd8, 64'd0, 1'b1, "R4 bad read");
            reg_rd_chk(12'(5 << 6), 4'd1, 64'd0, 1'b1, "R4 bad size read");
        end

        // Layout A: disabled overlap, small direct, SG, catch-all direct (R5 R6 R7 R8 R9 R10)
        reg_wr(0, 64'h0010_0000); reg_wr(4, 64'h0);          reg_wr(8,  64'hAAAA_AAAA_AAAA_AAAA);
        reg_wr(1, 64'h0000_0001); reg_wr(5, 64'h0030_0000);  reg_wr(9,  64'h0000_0002_8700_0000);
        reg_wr(2, 64'h4000_0003); reg_wr(6, 64'h0070_0000);  reg_wr(10, 64'h0000_0001_2345_6000);
        reg_wr(3, 64'h0000_0001); reg_wr(7, 64'h7FF0_0000);  reg_wr(11, 64'hFFFF_FFFF_FFFF_FFFF);
        sweep();

        // Layout B: SG priority over overlapping direct, wide SG, misses (R6 R10)
        reg_wr(0, 64'h7FF0_0003); reg_wr(4, 64'h0);          reg_wr(8,  64'h0000_0003_0000_0000);
        reg_wr(1, 64'h7F00_0001); reg_wr(5, 64'h00F0_0000);  reg_wr(9,  64'h0000_0001_0000_0000);
        reg_wr(2, 64'h2000_0003); reg_wr(6, 64'h1FF0_0000);  reg_wr(10, 64'h0000_0002_FFFF_FC00);
        reg_wr(3, 64'h2000_0000); reg_wr(7, 64'h7FF0_0000);  reg_wr(11, 64'h0000_0003_FFF0_0000);
        sweep();

        // R12: writes during an outstanding SG lookup apply to the next request only
        xlate(32'h7FF1_2345, 1'b0, 1'b1);
        xlate(32'h7FF1_2345, 1'b1, 1'b0);
        xlate(32'h7FF6_789A, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule